// File: doc/BRIEF.md
# Signed Boot Record Loader

This block walks a byte stream fetched one byte at a time from a serial boot memory. After a start pulse it takes bytes over a valid/ready interface and checks that the first four bytes spell the ASCII tag "WLS5". If the tag is wrong, the block reports that this boot source is skipped and takes nothing more. If the tag is right, it reads a chain of typed records and copies each payload byte into one of three memory spaces through a single-entry write port.

Every record starts with a five-byte header: a type byte, then a 16-bit payload length and a 16-bit target address, each low byte first. Types 0, 1 and 2 carry payload for the instruction, X-data and Y-data spaces. Type 3 ends the walk and reports its address as the entry point. Any other type is passed over by dropping its payload. If the input marks its last byte before an execute record has arrived, the walk ends with an error.

Top module: `boot_rec_loader`

## Requirements
- R1: If stream bytes 0 to 3 are not 0x57 0x4C 0x53 0x35, a one-cycle `skip_o` pulse follows the fourth byte. Exactly four bytes are taken and no write is issued.
- R2: Record headers begin at stream offset 4. A header is five bytes, in this order: type, length low, length high, address low, address high.
- R3: For each payload byte of a type 0, 1 or 2 record, the block issues one write. `wr_space_o` equals the type (0 instruction, 1 X, 2 Y), `wr_addr_o` is the record address plus the byte's offset modulo 2^16, and `wr_data_o` is the byte.
- R4: A type 3 header gives one `done_o` pulse, with `exec_addr_o` set to its address. No byte after that header is taken.
- R5: A record of type 4 to 255 has exactly its length in payload bytes discarded without writes. Parsing then resumes at the next header.
- R6: A record of length zero issues no writes, and the next byte is read as a new header.
- R7: If a byte flagged `in_last_i` is taken before an execute header has completed (other than the fourth signature byte of a mismatching tag), the block gives one `error_o` pulse and returns to idle.
- R8: While `wr_valid_o` is high and `wr_ready_i` is low, `in_ready_o` is low. A stalled write holds its values.
- R9: After reset, `in_ready_o`, `wr_valid_o`, `done_o`, `skip_o` and `error_o` are low, and the block waits for `start_i`.
- R10: Each started walk ends with exactly one pulse on one of `done_o`, `skip_o` or `error_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a walk from idle |
| in_valid_i | input | 1 | Stream byte valid |
| in_data_i | input | 8 | Stream byte |
| in_last_i | input | 1 | This byte is the last of the stream |
| in_ready_o | output | 1 | Block takes the byte |
| wr_valid_o | output | 1 | Write strobe pending |
| wr_ready_i | input | 1 | Memory side accepts the write |
| wr_space_o | output | 2 | Target space: 0 instr, 1 X, 2 Y |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 8 | Write byte |
| done_o | output | 1 | Execute record reached (pulse) |
| exec_addr_o | output | 16 | Entry address from the execute record |
| skip_o | output | 1 | Signature mismatch (pulse) |
| error_o | output | 1 | Stream ended early (pulse) |

## Verification
The hardest condition to reach is a payload byte arriving while the previous write is still held by a low `wr_ready_i`. The same goes for a stream that ends in the middle of a payload while a write is still in flight. The bench toggles `wr_ready_i` and `in_valid_i` at random on every cycle across many generated record chains, including unknown types, zero lengths, addresses that wrap, and cut-off streams, so these overlaps occur many times. Directed streams then pin down the signature, wrap and truncation edges.

// File: rtl/brl_pkg.sv
package brl_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int LEN_W    = 16;
    localparam int SPACE_W  = 2;
    localparam int IDX_W    = 3;

    localparam logic [BYTE_W-1:0] TYPE_EXEC    = 8'd3;
    localparam logic [BYTE_W-1:0] TYPE_MEM_MAX = 8'd2;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SIG  = 3'd1,
        ST_HDR  = 3'd2,
        ST_PAY  = 3'd3,
        ST_DROP = 3'd4
    } walk_st_e;

    function automatic logic [BYTE_W-1:0] tag_byte(input logic [1:0] i);
        case (i)
            2'd0:    tag_byte = 8'h57;
            2'd1:    tag_byte = 8'h4C;
            2'd2:    tag_byte = 8'h53;
            default: tag_byte = 8'h35;
        endcase
    endfunction
endpackage

// File: rtl/brl_wr_stage.sv
module brl_wr_stage
    import brl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [SPACE_W-1:0] push_space_i,
    input  logic [ADDR_W-1:0]  push_addr_i,
    input  logic [BYTE_W-1:0]  push_data_i,
    output logic               free_o,
    output logic               wr_valid_o,
    input  logic               wr_ready_i,
    output logic [SPACE_W-1:0] wr_space_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o
);
    typedef struct packed {
        logic               full;
        logic [SPACE_W-1:0] space;
        logic [ADDR_W-1:0]  addr;
        logic [BYTE_W-1:0]  data;
    } slot_s;

    slot_s slot_d, slot_q;

    assign free_o = !slot_q.full || wr_ready_i;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.full && wr_ready_i) begin
            slot_d.full = 1'b0;
        end
        if (push_i) begin
            slot_d.full  = 1'b1;
            slot_d.space = push_space_i;
            slot_d.addr  = push_addr_i;
            slot_d.data  = push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign wr_valid_o = slot_q.full;
    assign wr_space_o = slot_q.space;
    assign wr_addr_o  = slot_q.addr;
    assign wr_data_o  = slot_q.data;

    // R8: nothing is pushed over a write that is still held
    p_push_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!slot_q.full || wr_ready_i));

    // R8: a stalled write keeps its values
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=>
            (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_space_o)));

    // R3: only the three memory spaces are ever addressed
    p_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_space_o != 2'd3));
endmodule

// File: rtl/brl_parser.sv
module brl_parser
    import brl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               in_valid_i,
    input  logic [BYTE_W-1:0]  in_data_i,
    input  logic               in_last_i,
    output logic               in_ready_o,
    input  logic               free_i,
    output logic               push_o,
    output logic [SPACE_W-1:0] push_space_o,
    output logic [ADDR_W-1:0]  push_addr_o,
    output logic [BYTE_W-1:0]  push_data_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  exec_addr_o,
    output logic               skip_o,
    output logic               error_o
);
    typedef struct packed {
        walk_st_e           st;
        logic [IDX_W-1:0]   idx;
        logic               bad;
        logic [BYTE_W-1:0]  kind;
        logic [LEN_W-1:0]   len;
        logic [ADDR_W-1:0]  base;
        logic [LEN_W-1:0]   cnt;
        logic               done;
        logic               skip;
        logic               err;
        logic [ADDR_W-1:0]  exec;
    } walk_s;

    walk_s w_d, w_q;
    logic  take;
    logic  last_of_rec;

    always_comb begin
        w_d    = w_q;
        w_d.done = 1'b0;
        w_d.skip = 1'b0;
        w_d.err  = 1'b0;
        in_ready_o   = (w_q.st != ST_IDLE) && free_i;
        take         = in_valid_i && in_ready_o;
        push_o       = 1'b0;
        push_space_o = w_q.kind[SPACE_W-1:0];
        push_addr_o  = w_q.base + ADDR_W'(w_q.cnt);
        push_data_o  = in_data_i;
        last_of_rec  = (w_q.cnt + LEN_W'(1)) == w_q.len;

        case (w_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    w_d.st  = ST_SIG;
                    w_d.idx = '0;
                    w_d.bad = 1'b0;
                end
            end
            ST_SIG: begin
                if (take) begin
                    w_d.idx = w_q.idx + IDX_W'(1);
                    if (w_q.idx == IDX_W'(3)) begin
                        w_d.st = ST_IDLE;
                        if (w_q.bad || in_data_i != tag_byte(2'd3)) begin
                            w_d.skip = 1'b1;
                        end else if (in_last_i) begin
                            w_d.err = 1'b1;
                        end else begin
                            w_d.st  = ST_HDR;
                            w_d.idx = '0;
                        end
                    end else begin
                        w_d.bad = w_q.bad || (in_data_i != tag_byte(w_q.idx[1:0]));
                        if (in_last_i) begin
                            w_d.err = 1'b1;
                            w_d.st  = ST_IDLE;
                        end
                    end
                end
            end
            ST_HDR: begin
                if (take) begin
                    w_d.idx = w_q.idx + IDX_W'(1);
                    case (w_q.idx)
                        3'd0: w_d.kind          = in_data_i;
                        3'd1: w_d.len[7:0]      = in_data_i;
                        3'd2: w_d.len[15:8]     = in_data_i;
                        3'd3: w_d.base[7:0]     = in_data_i;
                        default: w_d.base[15:8] = in_data_i;
                    endcase
                    if (w_q.idx == IDX_W'(4)) begin
                        w_d.idx = '0;
                        w_d.cnt = '0;
                        if (w_q.kind == TYPE_EXEC) begin
                            w_d.done = 1'b1;
                            w_d.exec = {in_data_i, w_q.base[7:0]};
                            w_d.st   = ST_IDLE;
                        end else if (in_last_i) begin
                            w_d.err = 1'b1;
                            w_d.st  = ST_IDLE;
                        end else if (w_q.len == '0) begin
                            w_d.st = ST_HDR;
                        end else if (w_q.kind <= TYPE_MEM_MAX) begin
                            w_d.st = ST_PAY;
                        end else begin
                            w_d.st = ST_DROP;
                        end
                    end else if (in_last_i) begin
                        w_d.err = 1'b1;
                        w_d.st  = ST_IDLE;
                    end
                end
            end
            ST_PAY, ST_DROP: begin
                if (take) begin
                    push_o  = (w_q.st == ST_PAY);
                    w_d.cnt = w_q.cnt + LEN_W'(1);
                    if (in_last_i) begin
                        w_d.err = 1'b1;
                        w_d.st  = ST_IDLE;
                    end else if (last_of_rec) begin
                        w_d.st  = ST_HDR;
                        w_d.idx = '0;
                    end
                end
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign done_o      = w_q.done;
    assign skip_o      = w_q.skip;
    assign error_o     = w_q.err;
    assign exec_addr_o = w_q.exec;

    // R10: at most one result pulse at a time
    p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({w_q.done, w_q.skip, w_q.err}));

    // R4: the done pulse lasts one cycle
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.done |=> !w_q.done);

    // R1: a skip is only decided while the tag is being read
    p_skip_from_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.skip |-> ($past(w_q.st) == ST_SIG));

    // R2: header parsing only follows the tag or another record
    p_hdr_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_q.st == ST_HDR) && ($past(w_q.st) != ST_HDR)) |-> (w_q.idx == '0));
endmodule

// File: rtl/boot_rec_loader.sv
module boot_rec_loader
    import brl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               in_valid_i,
    input  logic [BYTE_W-1:0]  in_data_i,
    input  logic               in_last_i,
    output logic               in_ready_o,
    output logic               wr_valid_o,
    input  logic               wr_ready_i,
    output logic [SPACE_W-1:0] wr_space_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               done_o,
    output logic [ADDR_W-1:0]  exec_addr_o,
    output logic               skip_o,
    output logic               error_o
);
    logic               free;
    logic               push;
    logic [SPACE_W-1:0] push_space;
    logic [ADDR_W-1:0]  push_addr;
    logic [BYTE_W-1:0]  push_data;

    brl_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .in_last_i    (in_last_i),
        .in_ready_o   (in_ready_o),
        .free_i       (free),
        .push_o       (push),
        .push_space_o (push_space),
        .push_addr_o  (push_addr),
        .push_data_o  (push_data),
        .done_o       (done_o),
        .exec_addr_o  (exec_addr_o),
        .skip_o       (skip_o),
        .error_o      (error_o)
    );

    brl_wr_stage u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push),
        .push_space_i (push_space),
        .push_addr_i  (push_addr),
        .push_data_i  (push_data),
        .free_o       (free),
        .wr_valid_o   (wr_valid_o),
        .wr_ready_i   (wr_ready_i),
        .wr_space_o   (wr_space_o),
        .wr_addr_o    (wr_addr_o),
        .wr_data_o    (wr_data_o)
    );

    // R8: input is held off while the write port is stalled
    p_ready_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |-> !in_ready_o);

    // R4: nothing is taken in the cycle the done pulse shows
    p_quiet_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !in_ready_o);
endmodule

// File: tb/boot_rec_loader_bench.sv
`timescale 1ns/1ps
module boot_rec_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, in_valid_i, in_last_i, wr_ready_i;
    logic [7:0]  in_data_i;
    logic        in_ready_o, wr_valid_o, done_o, skip_o, error_o;
    logic [1:0]  wr_space_o;
    logic [15:0] wr_addr_o, exec_addr_o;
    logic [7:0]  wr_data_o;

    always #2.5 clk = ~clk;

    boot_rec_loader u_boot_rec_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_last_i(in_last_i),
        .in_ready_o(in_ready_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
        .wr_space_o(wr_space_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .done_o(done_o), .exec_addr_o(exec_addr_o), .skip_o(skip_o), .error_o(error_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [7:0]  strm [0:511];
    int          slen;
    logic [1:0]  ex_sp [0:511];
    logic [15:0] ex_ad [0:511];
    logic [7:0]  ex_dt [0:511];
    int          ex_n, ex_kind, ex_cons;
    logic [15:0] ex_exec;
    logic [1:0]  gt_sp [0:511];
    logic [15:0] gt_ad [0:511];
    logic [7:0]  gt_dt [0:511];
    int          gt_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic void put(input logic [7:0] b);
        strm[slen] = b;
        slen++;
    endfunction

    function automatic void put_tag(input bit good);
        put(8'h57); put(8'h4C); put(good ? 8'h53 : 8'h58); put(8'h35);
    endfunction

    function automatic void put_hdr(input logic [7:0] t, input logic [15:0] l,
                                    input logic [15:0] a);
        put(t); put(l[7:0]); put(l[15:8]); put(a[7:0]); put(a[15:8]);
    endfunction

    // kinds: 0 done, 1 skip, 2 error
    function automatic void model();
        int pos;
        logic [7:0]  t;
        logic [15:0] l, a;
        ex_n = 0;
        if (slen < 4) begin ex_kind = 2; ex_cons = slen; return; end
        if (strm[0] != 8'h57 || strm[1] != 8'h4C || strm[2] != 8'h53 || strm[3] != 8'h35) begin
            ex_kind = 1; ex_cons = 4; return;
        end
        pos = 4;
        while (1) begin
            if (pos + 5 > slen) begin ex_kind = 2; ex_cons = slen; return; end
            t = strm[pos];
            l = {strm[pos+2], strm[pos+1]};
            a = {strm[pos+4], strm[pos+3]};
            if (t == 8'd3) begin ex_kind = 0; ex_exec = a; ex_cons = pos + 5; return; end
            pos += 5;
            for (int k = 0; k < int'(l); k++) begin
                if (pos >= slen) begin ex_kind = 2; ex_cons = slen; return; end
                if (t <= 8'd2) begin
                    ex_sp[ex_n] = t[1:0];
                    ex_ad[ex_n] = a + 16'(k);
                    ex_dt[ex_n] = strm[pos];
                    ex_n++;
                end
                pos++;
            end
        end
    endfunction

    task automatic run(input string tag);
        int idx = 0;
        bit fire = 0;
        int outcome = -1;
        int pulses = 0;
        int stall_bad = 0;
        int late_ready = 0;
        int wr_bad = 0;
        int cyc = 0;
        logic [15:0] got_exec = '0;
        model();
        gt_n = 0;
        @(posedge clk); #1; start_i = 1'b1;
        @(posedge clk); #1; start_i = 1'b0;
        while (outcome < 0 && cyc < 4000) begin
            if (fire) idx++;
            in_valid_i = (idx < slen) && ($urandom % 4 != 0);
            in_data_i  = (idx < slen) ? strm[idx] : 8'h00;
            in_last_i  = (idx == slen - 1);
            wr_ready_i = ($urandom % 3 != 0);
            @(negedge clk);
            fire = in_valid_i && in_ready_o;
            if (wr_valid_o && !wr_ready_i && in_ready_o) stall_bad++;
            if (wr_valid_o && wr_ready_i) begin
                gt_sp[gt_n] = wr_space_o; gt_ad[gt_n] = wr_addr_o; gt_dt[gt_n] = wr_data_o;
                gt_n++;
            end
            if (done_o)  begin outcome = 0; pulses++; got_exec = exec_addr_o; end
            if (skip_o)  begin outcome = 1; pulses++; end
            if (error_o) begin outcome = 2; pulses++; end
            @(posedge clk); #1;
            cyc++;
        end
        in_valid_i = 1'b0;
        wr_ready_i = 1'b1;
        for (int d = 0; d < 10; d++) begin
            @(negedge clk);
            if (in_ready_o) late_ready++;
            if (wr_valid_o) begin
                gt_sp[gt_n] = wr_space_o; gt_ad[gt_n] = wr_addr_o; gt_dt[gt_n] = wr_data_o;
                gt_n++;
            end
            if (done_o || skip_o || error_o) pulses++;
            @(posedge clk); #1;
        end
        for (int i = 0; i < gt_n && i < ex_n; i++) begin
            if (gt_sp[i] != ex_sp[i] || gt_ad[i] != ex_ad[i] || gt_dt[i] != ex_dt[i]) wr_bad++;
        end
        case (ex_kind)
            0: chk(outcome == 0, "R4", {tag, " done outcome"}, outcome, 0);
            1: chk(outcome == 1, "R1", {tag, " skip outcome"}, outcome, 1);
            default: chk(outcome == 2, "R7", {tag, " error outcome"}, outcome, 2);
        endcase
        if (ex_kind == 0) chk(got_exec == ex_exec, "R4", {tag, " exec address"}, got_exec, ex_exec);
        chk(idx == ex_cons, "R2", {tag, " bytes taken"}, idx, ex_cons);
        chk(gt_n == ex_n, tag, "write count", gt_n, ex_n);
        chk(wr_bad == 0, "R3", {tag, " write space/addr/data"}, wr_bad, 0);
        chk(stall_bad == 0, "R8", {tag, " ready during stall"}, stall_bad, 0);
        chk(late_ready == 0, "R4", {tag, " ready after end"}, late_ready, 0);
        chk(pulses == 1, "R10", {tag, " result pulses"}, pulses, 1);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; start_i = 1'b0; in_valid_i = 1'b0; in_data_i = '0;
        in_last_i = 1'b0; wr_ready_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!in_ready_o && !wr_valid_o && !done_o && !skip_o && !error_o, "R9",
            "reset outputs", {in_ready_o, wr_valid_o, done_o, skip_o, error_o}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!in_ready_o, "R9", "idle before start", in_ready_o, 0);

        // R1: wrong tag followed by an otherwise valid chain
        slen = 0; put_tag(0); put_hdr(8'd0, 16'd2, 16'h0100); put(8'hAA); put(8'hBB);
        put_hdr(8'd3, 16'd0, 16'h1234);
        run("R1");

        // R4: execute record right after the tag
        slen = 0; put_tag(1); put_hdr(8'd3, 16'd0, 16'hBEEF); put(8'h77);
        run("R4");

        // R3: all three spaces
        slen = 0; put_tag(1);
        put_hdr(8'd0, 16'd3, 16'h0010); put(8'h01); put(8'h02); put(8'h03);
        put_hdr(8'd1, 16'd2, 16'h2000); put(8'h11); put(8'h12);
        put_hdr(8'd2, 16'd1, 16'h3000); put(8'h21);
        put_hdr(8'd3, 16'd0, 16'h0040);
        run("R3");

        // R3: address wrap past 0xFFFF
        slen = 0; put_tag(1); put_hdr(8'd0, 16'd4, 16'hFFFE);
        put(8'hC0); put(8'hC1); put(8'hC2); put(8'hC3);
        put_hdr(8'd3, 16'd0, 16'h0000);
        run("R3");

        // R6: zero-length records
        slen = 0; put_tag(1); put_hdr(8'd1, 16'd0, 16'h5555); put_hdr(8'd2, 16'd0, 16'h6666);
        put_hdr(8'd2, 16'd1, 16'h0007); put(8'h99); put_hdr(8'd3, 16'd0, 16'h0101);
        run("R6");

        // R5: unknown types, including one with length zero
        slen = 0; put_tag(1); put_hdr(8'd7, 16'd4, 16'h0000);
        put(8'h03); put(8'h03); put(8'h03); put(8'h03);
        put_hdr(8'hFF, 16'd0, 16'h0000);
        put_hdr(8'd0, 16'd1, 16'h0400); put(8'h5A);
        put_hdr(8'd3, 16'd0, 16'h0ABC);
        run("R5");

        // R7: stream ends in a payload, in a header, and inside the tag
        slen = 0; put_tag(1); put_hdr(8'd1, 16'd5, 16'h0800); put(8'hE0); put(8'hE1);
        run("R7");
        slen = 0; put_tag(1); put(8'd0); put(8'd1);
        run("R7");
        slen = 0; put(8'h57); put(8'h4C);
        run("R7");
        slen = 0; put_tag(1);
        run("R7");

        // random chains
        for (int r = 0; r < 40; r++) begin
            int nrec;
            slen = 0;
            put_tag($urandom % 10 != 0);
            nrec = $urandom % 5;
            for (int j = 0; j < nrec; j++) begin
                logic [7:0]  t;
                logic [15:0] l;
                t = ($urandom % 6 == 5) ? 8'(4 + $urandom % 200) : 8'($urandom % 3);
                l = 16'($urandom % 7);
                put_hdr(t, l, 16'($urandom));
                for (int k = 0; k < int'(l); k++) put(8'($urandom));
            end
            if ($urandom % 5 != 0) put_hdr(8'd3, 16'd0, 16'($urandom));
            if ($urandom % 6 == 0 && slen > 1) slen = 1 + ($urandom % (slen - 1));
            run("R3");
        end

        finish_run();
    end
endmodule